// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the already-synchronized levels of one bank of general-purpose pins and turns selected conditions on them into a single interrupt request. Each pin can be set up on its own: it can trigger on a level or on an edge. For a level or a single edge, a sense bit picks the direction. An edge pin can also be told to trigger on both edges. Every detected condition is held in a pending register. Software clears a pending bit by writing a 1 to it.

A mask decides which pending bits reach the interrupt output. Detection and latching do not depend on the mask. A pin that is masked still collects its pending bit, and that bit drives the output as soon as the pin is unmasked. The mask has two write-only registers, one that sets mask bits and one that clears them, plus a read-only register that shows the mask. So software never does a read-modify-write on the mask. Register access is a simple single-cycle write port and a combinational read port with word addresses.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset every mask bit reads 1, the pending, kind, sense and both-edge registers read 0, and `irq_o` is 0.
- R2: A pin whose kind bit is 0 is level-sensitive: sense bit 1 means active-high, sense bit 0 means active-low. Its pending bit is set again on every clock edge at which the active level is present, so a clear has no lasting effect while the level remains.
- R3: A pin whose kind bit is 1 and both-edge bit is 0 is edge-sensitive. The level sampled at a clock edge is compared with the level sampled at the previous edge. Sense 1 catches a low-to-high change and sense 0 a high-to-low change.
- R4: A pin whose kind bit is 1 and both-edge bit is 1 triggers on every change of level, whatever its sense bit. The both-edge bit has no effect on a level-sensitive pin.
- R5: Writing the pending register (word address 3) clears every bit written as 1 and leaves bits written as 0 unchanged. A new event in the same cycle as a clear of its bit leaves the bit set.
- R6: A pending bit stays set from the edge that latched it until it is cleared.
- R7: Writing word address 4 clears the mask bits written as 1, and writing word address 5 sets the mask bits written as 1. Zero bits leave the mask unchanged, and an all-ones write to address 5 masks the whole bank. Word address 6 reads the mask, where 1 means masked.
- R8: `irq_o` is 1 in exactly those cycles where some pending bit has its mask bit at 0. It follows the registers with no extra delay.
- R9: Events on masked pins are still latched in the pending register, and they raise `irq_o` in the cycle after the unmask write takes effect.
- R10: Word addresses 0, 1 and 2 hold the kind, sense and both-edge registers (read/write). Addresses 4 and 5 read as 0. Writes to address 6 and to address 7 change nothing, and address 7 reads as 0. A configuration write takes effect for detection from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Synchronized pin levels of the bank |
| wr_en_i | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr_i | input | 3 | Word address of the write |
| wr_data_i | input | NUM_PINS | Write data, one bit per pin |
| rd_addr_i | input | 3 | Word address of the read |
| rd_data_o | output | NUM_PINS | Read data for `rd_addr_i`, combinational |
| irq_o | output | 1 | Bank interrupt request |

## Verification
A wrong previous-level sample or a wrong sense bit shows up as a pending bit that appears, or fails to appear, at the edge after the pin changes. It can be read back at address 3 in the same cycle. A mask register that has drifted shows up at once on `irq_o` whenever a pending bit exists, and it can also be read at address 6. A clear that beats a new event, or a pending bit that decays, loses an interrupt: the loss shows within one cycle at the pending read and on `irq_o`. For that reason the bench compares `irq_o` and one register read against its own model after every clock edge.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/100ps
// Package: gpio_irq_pkg
// Register word addresses shared by the interrupt detector and its bench.
// Assumes a word-addressed port, one register per address.
package gpio_irq_pkg;

    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned NUM_CFG = 3;

    // Configuration registers must be consecutive from CFG_BASE.
    localparam logic [ADDR_W-1:0] ADR_KIND     = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SENSE    = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_BOTH     = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PEND     = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_UNMASK   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_MASK     = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_MASKVIEW = 3'd6;
    localparam logic [ADDR_W-1:0] CFG_BASE     = ADR_KIND;

endpackage

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/100ps
// Module: gpio_irq_cfg
// Holds the per-pin kind, sense and both-edge configuration and the mask.
// The mask is changed only through its set and clear addresses.
// Assumes at most one write per cycle; reset masks every pin.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    output logic [NUM_PINS-1:0] kind_o,
    output logic [NUM_PINS-1:0] sense_o,
    output logic [NUM_PINS-1:0] both_o,
    output logic [NUM_PINS-1:0] mask_o
);

    localparam int unsigned FLAT_W = NUM_CFG * NUM_PINS;

    logic [FLAT_W-1:0]   cfg_flat;
    logic [NUM_PINS-1:0] mask_q;
    logic                hit_unmask;
    logic                hit_mask;

    // One plain read/write register per configuration address.
    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        logic [NUM_PINS-1:0] q;
        logic                hit;

        assign hit = wr_en_i && (wr_addr_i == (CFG_BASE + ADDR_W'(k)));

        // Load the register on a write to its address; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit) begin
                q <= wr_data_i;
            end
        end

        assign cfg_flat[k*NUM_PINS +: NUM_PINS] = q;
    end

    assign kind_o  = cfg_flat[0*NUM_PINS +: NUM_PINS];
    assign sense_o = cfg_flat[1*NUM_PINS +: NUM_PINS];
    assign both_o  = cfg_flat[2*NUM_PINS +: NUM_PINS];

    assign hit_unmask = wr_en_i && (wr_addr_i == ADR_UNMASK);
    assign hit_mask   = wr_en_i && (wr_addr_i == ADR_MASK);

    // Mask: write-1-to-clear at one address, write-1-to-set at the other.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (hit_unmask) begin
            mask_q <= mask_q & ~wr_data_i;
        end else if (hit_mask) begin
            mask_q <= mask_q | wr_data_i;
        end
    end

    assign mask_o = mask_q;

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_unmask |=> ((mask_q & $past(wr_data_i)) == '0));                           // R7
    AST_UNMASK_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_unmask |=> ((mask_q & ~$past(wr_data_i)) == ($past(mask_q) & ~$past(wr_data_i)))); // R7
    AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mask |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));               // R7
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_mask || hit_unmask) |=> $stable(mask_q));                                // R10

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/100ps
// Module: gpio_irq_detect
// Per-pin event detection: level or edge, chosen polarity, optional both edges.
// Assumes pin_i is already synchronized to clk. Edges are found by comparing
// with the level sampled at the previous edge. That sample is also taken during
// reset, so no edge is seen on the first cycle after reset.
module gpio_irq_detect #(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] kind_i,
    input  logic [NUM_PINS-1:0] sense_i,
    input  logic [NUM_PINS-1:0] both_i,
    output logic [NUM_PINS-1:0] evt_o
);

    logic [NUM_PINS-1:0] prev_q;

    // Previous-level sample; tracks the pins in and out of reset.
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise;
        logic fall;

        assign rise = pin_i[p] & ~prev_q[p];
        assign fall = ~pin_i[p] & prev_q[p];

        // Select the event condition for this pin from its configuration.
        always_comb begin
            if (!kind_i[p]) begin
                evt_o[p] = sense_i[p] ? pin_i[p] : ~pin_i[p];
            end else if (both_i[p]) begin
                evt_o[p] = rise | fall;
            end else begin
                evt_o[p] = sense_i[p] ? rise : fall;
            end
        end
    end

    AST_LEVEL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ((~kind_i & ~(pin_i ^ sense_i) & ~evt_o) == '0));                              // R2
    AST_EDGE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind_i & ~(pin_i ^ $past(pin_i)) & evt_o) == '0));                            // R3
    AST_BOTH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind_i & both_i & (pin_i ^ $past(pin_i)) & ~evt_o) == '0));                   // R4

endmodule

// File: rtl/gpio_irq_pend.sv
`timescale 1ns/100ps
// Module: gpio_irq_pend
// Pending register with write-1-to-clear and interrupt aggregation.
// Assumes evt_i and clr_i are valid for the current clock edge. A new event
// wins over a clear of the same bit. The mask only gates the output.
module gpio_irq_pend #(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic [NUM_PINS-1:0] clr_i,
    input  logic [NUM_PINS-1:0] mask_i,
    output logic [NUM_PINS-1:0] pend_o,
    output logic                irq_o
);

    logic [NUM_PINS-1:0] pend_q;

    // Latch events; clear written bits unless an event arrives with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | evt_i;
        end
    end

    // Request whenever an unmasked pending bit exists.
    always_comb begin
        irq_o = |(pend_q & ~mask_i);
    end

    assign pend_o = pend_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(evt_i)) == $past(evt_i)));                            // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(clr_i & ~evt_i)) == '0));                             // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q & ~clr_i) & ~pend_q) == '0));                           // R6

endmodule

// File: rtl/gpio_irq_detector.sv
`timescale 1ns/100ps
// Module: gpio_irq_detector
// Top of the bank interrupt detector: configuration, detection, pending
// register and the combinational register read mux.
// Assumes synchronized pins and a single-cycle word-addressed write port.
module gpio_irq_detector
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [NUM_PINS-1:0] rd_data_o,
    output logic                irq_o
);

    logic [NUM_PINS-1:0] kind_w;
    logic [NUM_PINS-1:0] sense_w;
    logic [NUM_PINS-1:0] both_w;
    logic [NUM_PINS-1:0] mask_w;
    logic [NUM_PINS-1:0] evt_w;
    logic [NUM_PINS-1:0] clr_w;
    logic [NUM_PINS-1:0] pend_w;

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .kind_o    (kind_w),
        .sense_o   (sense_w),
        .both_o    (both_w),
        .mask_o    (mask_w)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .kind_i  (kind_w),
        .sense_i (sense_w),
        .both_i  (both_w),
        .evt_o   (evt_w)
    );

    // Clear vector: data of a write aimed at the pending register.
    always_comb begin
        clr_w = (wr_en_i && (wr_addr_i == ADR_PEND)) ? wr_data_i : '0;
    end

    gpio_irq_pend #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_w),
        .clr_i  (clr_w),
        .mask_i (mask_w),
        .pend_o (pend_w),
        .irq_o  (irq_o)
    );

    // Read mux; write-only and unused addresses read as zero.
    always_comb begin
        case (rd_addr_i)
            ADR_KIND:     rd_data_o = kind_w;
            ADR_SENSE:    rd_data_o = sense_w;
            ADR_BOTH:     rd_data_o = both_w;
            ADR_PEND:     rd_data_o = pend_w;
            ADR_MASKVIEW: rd_data_o = mask_w;
            default:      rd_data_o = '0;
        endcase
    end

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '1) |-> !irq_o);                                                    // R8
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_w != '0));                                                     // R8

endmodule

// File: tb/sim_gpio_irq_detector.sv
`timescale 1ns/100ps
// Bench for gpio_irq_detector: directed corner cases, then seeded random
// traffic, all checked against a register model kept in the bench.
module sim_gpio_irq_detector;
    import gpio_irq_pkg::*;

    localparam int unsigned N = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  pin;
    logic          wr_en;
    logic [2:0]    wr_addr;
    logic [N-1:0]  wr_data;
    logic [2:0]    rd_addr;
    logic [N-1:0]  rd_data;
    logic          irq;

    int errs   = 0;
    int checks = 0;

    logic [N-1:0] m_kind, m_sense, m_both, m_mask, m_pend, m_prev;

    always #5 clk = ~clk;

    gpio_irq_detector #(.NUM_PINS(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    function automatic logic [N-1:0] f_evt(input logic [N-1:0] p, input logic [N-1:0] pv,
                                           input logic [N-1:0] k, input logic [N-1:0] s,
                                           input logic [N-1:0] b);
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) begin
            if (!k[i])     e[i] = s[i] ? p[i] : ~p[i];
            else if (b[i]) e[i] = p[i] ^ pv[i];
            else if (s[i]) e[i] = p[i] & ~pv[i];
            else           e[i] = ~p[i] & pv[i];
        end
        return e;
    endfunction

    function automatic logic [N-1:0] f_read(input logic [2:0] a);
        case (a)
            3'd0: return m_kind;
            3'd1: return m_sense;
            3'd2: return m_both;
            3'd3: return m_pend;
            3'd6: return m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_irq(input string tag);
        chk({tag, " irq (R8)"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_pend & ~m_mask)});
    endtask

    task automatic check_all(input string tag);
        check_irq(tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.2;
            chk($sformatf("%s rd%0d", tag, a), rd_data, f_read(3'(a)));
        end
    endtask

    // One clock: drive at the falling edge, update the model after the rising edge.
    task automatic cyc(input logic [N-1:0] p, input logic we, input logic [2:0] wa,
                       input logic [N-1:0] wd);
        logic [N-1:0] ev, clr, nk, ns, nb, nm;
        @(negedge clk);
        pin = p; wr_en = we; wr_addr = wa; wr_data = wd;
        ev  = f_evt(p, m_prev, m_kind, m_sense, m_both);
        clr = (we && wa == 3'd3) ? wd : '0;
        nk = (we && wa == 3'd0) ? wd : m_kind;
        ns = (we && wa == 3'd1) ? wd : m_sense;
        nb = (we && wa == 3'd2) ? wd : m_both;
        nm = m_mask;
        if (we && wa == 3'd4) nm = m_mask & ~wd;
        if (we && wa == 3'd5) nm = m_mask | wd;
        @(posedge clk);
        #1;
        m_pend = (m_pend & ~clr) | ev;
        m_kind = nk; m_sense = ns; m_both = nb; m_mask = nm; m_prev = p;
        wr_en = 1'b0;
    endtask

    task automatic idle(input logic [N-1:0] p);
        cyc(p, 1'b0, 3'd7, '0);
    endtask

    localparam logic [N-1:0] ONES = '1;
    localparam logic [N-1:0] P1LO = 32'hFFFF_FFFC;   // pins 0 and 1 low
    localparam logic [N-1:0] P1HI = 32'hFFFF_FFFE;   // pin 0 low, pin 1 high

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pin = ONES; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_kind = '0; m_sense = '0; m_both = '0; m_pend = '0; m_mask = '1; m_prev = ONES;
        check_all("R1 reset");

        cyc(ONES, 1'b1, ADR_UNMASK, 32'h0000_FFFF); check_all("R7 unmask low half");
        cyc(ONES, 1'b1, ADR_SENSE, 32'h0000_0001);  check_all("R10 sense write");
        idle(ONES);                                 check_all("R2 level high latched");
        cyc(ONES, 1'b1, ADR_PEND, 32'h0000_0001);   check_all("R2 clear while active");
        cyc(ONES, 1'b1, ADR_PEND, 32'h0000_0000);   check_all("R5 zero write keeps");
        cyc(P1HI, 1'b1, ADR_PEND, 32'h0000_0001);   check_all("R5 clear after level gone");

        cyc(P1LO, 1'b1, ADR_KIND, 32'h0000_0002);   check_all("R10 kind write");
        cyc(P1LO, 1'b1, ADR_SENSE, 32'h0000_0003);  check_all("R3 setup rising");
        cyc(P1LO, 1'b1, ADR_PEND, ONES);            check_all("R5 clear all");
        idle(P1LO);                                 check_all("R3 no change no event");
        idle(P1HI);                                 check_all("R3 rising caught");
        cyc(P1HI, 1'b1, ADR_SENSE, 32'h0000_0001);  check_all("R3 setup falling");
        cyc(P1HI, 1'b1, ADR_PEND, 32'h0000_0002);   check_all("R5 clear pin1");
        idle(P1LO);                                 check_all("R3 falling caught");
        cyc(P1LO, 1'b1, ADR_PEND, 32'h0000_0002);   check_all("R5 clear pin1 again");
        idle(P1HI);                                 check_all("R3 rising ignored when falling");

        cyc(P1HI, 1'b1, ADR_BOTH, 32'h0000_0003);   check_all("R4 both set");
        cyc(P1HI, 1'b1, ADR_PEND, ONES);            check_all("R4 clear");
        idle(P1LO);                                 check_all("R4 falling caught");
        cyc(P1LO, 1'b1, ADR_PEND, ONES);            check_all("R4 clear again");
        idle(P1HI);                                 check_all("R4 rising caught, level pin0 idle");

        cyc(P1LO, 1'b1, ADR_PEND, 32'h0000_0002);   check_all("R5 set beats clear");
        cyc(P1LO, 1'b1, ADR_PEND, ONES);            check_all("R6 clear before mask test");

        cyc(P1LO, 1'b1, ADR_MASK, 32'h0000_0002);   check_all("R9 mask pin1");
        idle(P1HI);                                 check_all("R9 masked event latched");
        idle(P1HI);                                 check_all("R6 pending holds");
        cyc(P1HI, 1'b1, ADR_UNMASK, 32'h0000_0002); check_all("R9 unmask propagates");
        cyc(P1HI, 1'b1, ADR_MASK, ONES);            check_all("R7 mask all ones");
        cyc(P1HI, 1'b1, ADR_MASKVIEW, 32'h0);       check_all("R10 mask view read-only");
        cyc(P1HI, 1'b1, 3'd7, ONES);                check_all("R10 unused address");

        for (int i = 0; i < 600; i++) begin
            logic [2:0] ra;
            cyc($urandom(), ($urandom() % 3) == 0, 3'($urandom() % 8), $urandom());
            check_irq("R8 random");
            ra = 3'($urandom() % 8);
            rd_addr = ra;
            #0.2;
            chk($sformatf("R8 random rd%0d", ra), rd_data, f_read(ra));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule